// File: doc/BRIEF.md
# Transmit Descriptor Ring Poller

The block drives the transmit side of a small Ethernet MAC. A ring of buffer descriptors is kept in memory that software and the MAC both use. Each slot is two words: an info word, then a buffer pointer. The engine reads the info word of its current slot. If the MAC owns the slot, the engine fetches the pointer, hands the buffer to the frame sender, and then rewrites the info word. The rewritten word returns ownership to software and carries the send status. After that the engine moves straight on to the next slot. When it meets a slot that software still owns, the engine stops on that index and sleeps. It wakes again when a programmable poll timer expires or when software raises a force-poll strobe.

Software supplies three things: a control word, the ring base address and a poll interval. The control word contains the enables and the ring length. Frame serialisation lies outside this block. The sender only sees a pointer, a length and the first/last marks, and it answers with a done strobe and six status flags. Each completed slot gives a done event. A slot marked first but not last gives a chaining-error event as well.

Top module: `txring_poller`

## Requirements
- R1: Slot i sits at base + 8*i, with the info word first and the buffer pointer at +4. The pointer is fetched only when info bit 31 (ownership, 1 = MAC) reads 1, and the send uses that pointer.
- R2: When the info word has bit 31 clear, the engine stays on the same index and does not fetch the pointer. It returns to waiting and starts the next automatic check after the idle counter has run from the poll interval N down to 0. With an immediate grant and a one-cycle read response, successive info reads are therefore N+3 cycles apart.
- R3: A force-poll seen while the engine waits starts an info read in the next cycle. A force-poll that arrives while the engine is busy is remembered until an info read is accepted. A force-poll in the same cycle as that acceptance stays remembered and causes one more check right after the current one.
- R4: The engine runs only while control bit 0 and control bit 3 are both 1. Otherwise it starts no check, it ignores force-poll, and its index goes back to 0.
- R5: During a send, send_valid holds the pointer, the length from info bits 10:0, first from info bit 16 and last from info bit 17. These stay unchanged until send_done, and no memory request is made during the send.
- R6: The write-back to the info word clears bit 31. It keeps bits 17:16 and 10:0 as read and zeroes every other bit except the status flags. The flags go in as follows: send_stat[0] to bit 21, [1] to bit 22, [2] to bit 23, [3] to bit 24, [4] to bit 28, [5] to bit 29.
- R7: ev_tx_done pulses for one cycle, one cycle after the write-back is accepted. ev_chain_err pulses in the same cycle when the slot had bit 16 set and bit 17 clear.
- R8: The ring length comes from control bits 23:16. After a write-back the index goes to the next slot, and from length-1 it goes to 0 (a length of 0 or 1 keeps it at 0). If the engine is still enabled it checks the new slot at once.
- R9: A memory request keeps its address, direction and data unchanged until mem_ack. Read data is taken on mem_rvalid, which comes at least one cycle after the read was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | 32 | Control word: bit 0 global enable, bit 3 transmit enable, bits 23:16 ring length |
| cfg_base | input | AW | Ring base address (8-byte aligned) |
| cfg_poll_rate | input | RATE_W | Idle cycles between automatic checks |
| force_poll | input | 1 | Strobe requesting an immediate check |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| send_valid | output | 1 | Frame send request |
| send_addr | output | 32 | Buffer pointer of the frame |
| send_len | output | 11 | Buffer length in bytes |
| send_first | output | 1 | First-buffer mark |
| send_last | output | 1 | Last-buffer mark |
| send_done | input | 1 | Frame sent, send_stat valid |
| send_stat | input | 6 | Send status flags |
| ev_tx_done | output | 1 | Slot completed pulse |
| ev_chain_err | output | 1 | Chained-frame pulse |

## Verification
The delicate overlap is a force-poll in the very cycle in which the engine's own info read is accepted. In that cycle the pending flag is being cleared and set together. The bench watches for the cycle in which mem_req is high and holds force_poll there. The slot is software-owned and the poll interval is long, so the test separates the two outcomes cleanly. The next info read must come exactly three cycles later, and after that there must be no further read. A lost strobe would show up as a missing read and a doubled one as an extra read. A second overlap is a timer expiry together with a force-poll. Both must produce one check, and the measured read spacing under a fixed interval catches a double start.

// File: rtl/txring_pkg.sv
package txring_pkg;

  // Info word field positions (shared with the software side).
  localparam int OWN_BIT   = 31;
  localparam int FIRST_BIT = 16;
  localparam int LAST_BIT  = 17;
  localparam int LEN_W     = 11;

  // Control word fields.
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_TXEN_BIT = 3;
  localparam int RLEN_LSB      = 16;
  localparam int RLEN_W        = 8;

  // Send status flags and their place in the written-back info word.
  localparam int STAT_W = 6;
  localparam int unsigned STAT_POS [STAT_W] = '{21, 22, 23, 24, 28, 29};

  // Bits of the read info word carried into the write-back.
  localparam logic [31:0] KEEP_MASK =
    (32'h1 << FIRST_BIT) | (32'h1 << LAST_BIT) | ((32'h1 << LEN_W) - 32'h1);

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_INFO_REQ,
    ST_INFO_RSP,
    ST_PTR_REQ,
    ST_PTR_RSP,
    ST_SEND,
    ST_WBACK
  } tx_state_e;

endpackage

// File: rtl/txring_poll_timer.sv
module txring_poll_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              idle,
  input  logic [RATE_W-1:0] rate,
  input  logic              force_poll,
  input  logic              info_taken,
  output logic              fire
);

  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              pend_q, pend_d;

  // Countdown: reloaded whenever the engine is busy or stopped.
  always_comb begin
    cnt_d = cnt_q;
    if (!run || !idle) begin
      cnt_d = rate;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - RATE_W'(1);
    end
  end

  // Remembered force request; a new strobe wins over the clear.
  always_comb begin
    pend_d = pend_q;
    if (!run) begin
      pend_d = 1'b0;
    end else if (force_poll) begin
      pend_d = 1'b1;
    end else if (info_taken) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign fire = run && idle && ((cnt_q == '0) || pend_q || force_poll);

endmodule

// File: rtl/txring_ring_index.sv
module txring_ring_index #(
  parameter int IDX_W = 8,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [IDX_W-1:0] ring_len,
  input  logic             step,
  input  logic             ptr_sel,
  input  logic [AW-1:0]    base,
  output logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    slot_addr
);

  localparam int SLOT_SHIFT = 3;
  localparam int PTR_OFS    = 4;

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W:0]   idx_inc;
  logic             at_end;

  assign idx_inc = {1'b0, idx_q} + (IDX_W+1)'(1);
  assign at_end  = idx_inc >= {1'b0, ring_len};

  always_comb begin
    idx_d = idx_q;
    if (!run) begin
      idx_d = '0;
    end else if (step) begin
      idx_d = at_end ? '0 : idx_inc[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end

  assign idx       = idx_q;
  assign slot_addr = base + (AW'(idx_q) << SLOT_SHIFT) + (ptr_sel ? AW'(PTR_OFS) : '0);

endmodule

// File: rtl/txring_wbmerge.sv
module txring_wbmerge
  import txring_pkg::*;
(
  input  logic [31:0]       info,
  input  logic [STAT_W-1:0] stat,
  output logic [31:0]       word
);

  logic [31:0] part [STAT_W];
  logic [31:0] flags;

  for (genvar g = 0; g < STAT_W; g++) begin : g_flag
    assign part[g] = {31'b0, stat[g]} << STAT_POS[g];
  end

  always_comb begin
    flags = '0;
    for (int i = 0; i < STAT_W; i++) begin
      flags = flags | part[i];
    end
  end

  // Ownership bit is not in KEEP_MASK, so it always leaves as 0.
  assign word = (info & KEEP_MASK) | flags;

endmodule

// File: rtl/txring_poller.sv
module txring_poller
  import txring_pkg::*;
#(
  parameter int AW     = 32,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_ctrl,
  input  logic [AW-1:0]     cfg_base,
  input  logic [RATE_W-1:0] cfg_poll_rate,
  input  logic              force_poll,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              send_valid,
  output logic [31:0]       send_addr,
  output logic [LEN_W-1:0]  send_len,
  output logic              send_first,
  output logic              send_last,
  input  logic              send_done,
  input  logic [STAT_W-1:0] send_stat,
  output logic              ev_tx_done,
  output logic              ev_chain_err
);

  tx_state_e          st_q, st_d;
  logic               run;
  logic [RLEN_W-1:0]  ring_len;
  logic               fire;
  logic               info_taken;
  logic               step;
  logic [RLEN_W-1:0]  idx;
  logic [AW-1:0]      slot_addr;
  logic [31:0]        wb_word;

  logic [31:0]        info_q;
  logic [31:0]        ptr_q;
  logic [STAT_W-1:0]  stat_q;
  logic               info_en, ptr_en, stat_en;
  logic               ev_done_q, ev_chain_q;
  logic               ev_done_d, ev_chain_d;

  assign run      = cfg_ctrl[CTRL_EN_BIT] & cfg_ctrl[CTRL_TXEN_BIT];
  assign ring_len = cfg_ctrl[RLEN_LSB +: RLEN_W];

  assign info_taken = (st_q == ST_INFO_REQ) && mem_ack;
  assign step       = (st_q == ST_WBACK) && mem_ack;

  txring_poll_timer #(.RATE_W(RATE_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .idle       (st_q == ST_WAIT),
    .rate       (cfg_poll_rate),
    .force_poll (force_poll),
    .info_taken (info_taken),
    .fire       (fire)
  );

  txring_ring_index #(.IDX_W(RLEN_W), .AW(AW)) u_index (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .ring_len  (ring_len),
    .step      (step),
    .ptr_sel   (st_q == ST_PTR_REQ),
    .base      (cfg_base),
    .idx       (idx),
    .slot_addr (slot_addr)
  );

  txring_wbmerge u_merge (
    .info (info_q),
    .stat (stat_q),
    .word (wb_word)
  );

  // Next-state logic of the descriptor walk.
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAIT:     if (fire) st_d = ST_INFO_REQ;
      ST_INFO_REQ: if (mem_ack) st_d = ST_INFO_RSP;
      ST_INFO_RSP: if (mem_rvalid) st_d = mem_rdata[OWN_BIT] ? ST_PTR_REQ : ST_WAIT;
      ST_PTR_REQ:  if (mem_ack) st_d = ST_PTR_RSP;
      ST_PTR_RSP:  if (mem_rvalid) st_d = ST_SEND;
      ST_SEND:     if (send_done) st_d = ST_WBACK;
      ST_WBACK:    if (mem_ack) st_d = run ? ST_INFO_REQ : ST_WAIT;
      default:     st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_WAIT;
    end else begin
      st_q <= st_d;
    end
  end

  // Captured descriptor fields and send status (no reset, explicit enables).
  assign info_en = (st_q == ST_INFO_RSP) && mem_rvalid;
  assign ptr_en  = (st_q == ST_PTR_RSP) && mem_rvalid;
  assign stat_en = (st_q == ST_SEND) && send_done;

  always_ff @(posedge clk) begin
    if (info_en) info_q <= mem_rdata;
    if (ptr_en)  ptr_q  <= mem_rdata;
    if (stat_en) stat_q <= send_stat;
  end

  // Completion events, registered.
  assign ev_done_d  = step;
  assign ev_chain_d = step && info_q[FIRST_BIT] && !info_q[LAST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_done_q  <= 1'b0;
      ev_chain_q <= 1'b0;
    end else begin
      ev_done_q  <= ev_done_d;
      ev_chain_q <= ev_chain_d;
    end
  end

  assign mem_req   = (st_q == ST_INFO_REQ) || (st_q == ST_PTR_REQ) || (st_q == ST_WBACK);
  assign mem_we    = (st_q == ST_WBACK);
  assign mem_addr  = slot_addr;
  assign mem_wdata = wb_word;

  assign send_valid = (st_q == ST_SEND);
  assign send_addr  = ptr_q;
  assign send_len   = info_q[LEN_W-1:0];
  assign send_first = info_q[FIRST_BIT];
  assign send_last  = info_q[LAST_BIT];

  assign ev_tx_done   = ev_done_q;
  assign ev_chain_err = ev_chain_q;

endmodule

// File: rtl/txring_poller_chk.sv
module txring_poller_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cfg_base,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          send_valid,
  input logic          send_done,
  input logic [31:0]   send_addr,
  input logic [10:0]   send_len,
  input logic          ev_tx_done,
  input logic          ev_chain_err
);

  logic [AW-1:0] rel_addr;
  assign rel_addr = mem_addr - cfg_base;

  // R9: a pending request does not change until granted
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R5: send request is held with fixed contents until done
  a_r5_send_hold: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid && !send_done |=> send_valid && $stable(send_addr) && $stable(send_len));

  // R5: no memory traffic while a frame is being sent
  a_r5_quiet_mem: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid |-> !mem_req);

  // R6: write-back always returns the slot to software
  a_r6_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  // R1: write-back targets the info word of a slot
  a_r1_wb_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> rel_addr[2:0] == 3'b000);

  // R7: chaining event only together with a done event
  a_r7_chain_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chain_err |-> ev_tx_done);

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done |=> !ev_tx_done);

endmodule

bind txring_poller txring_poller_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_base     (cfg_base),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ack      (mem_ack),
  .send_valid   (send_valid),
  .send_done    (send_done),
  .send_addr    (send_addr),
  .send_len     (send_len),
  .ev_tx_done   (ev_tx_done),
  .ev_chain_err (ev_chain_err)
);

// File: tb/test_txring_poller.sv
module test_txring_poller;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_ctrl = 32'h0;
  logic [31:0] cfg_base = 32'h40;
  logic [15:0] cfg_poll_rate = 16'd5;
  logic        force_poll = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'h0;
  logic        send_valid, send_first, send_last;
  logic [31:0] send_addr;
  logic [10:0] send_len;
  logic        send_done = 1'b0;
  logic [5:0]  send_stat;
  logic        ev_tx_done, ev_chain_err;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  logic ack_slow = 1'b0;

  always #5 clk = ~clk;

  txring_poller i_txring_poller (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_base(cfg_base),
    .cfg_poll_rate(cfg_poll_rate), .force_poll(force_poll),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .send_valid(send_valid), .send_addr(send_addr), .send_len(send_len),
    .send_first(send_first), .send_last(send_last), .send_done(send_done),
    .send_stat(send_stat), .ev_tx_done(ev_tx_done), .ev_chain_err(ev_chain_err)
  );

  function automatic logic [5:0] stat_of(input logic [31:0] p);
    return p[13:8] ^ 6'h2a;
  endfunction

  function automatic logic [31:0] wb_exp(input logic [31:0] info, input logic [5:0] s);
    return (info & 32'h0003_07FF) | ({31'b0, s[0]} << 21) | ({31'b0, s[1]} << 22) |
           ({31'b0, s[2]} << 23) | ({31'b0, s[3]} << 24) | ({31'b0, s[4]} << 28) |
           ({31'b0, s[5]} << 29);
  endfunction

  assign mem_ack   = ack_slow ? (cyc[1:0] == 2'b00) : 1'b1;
  assign send_stat = stat_of(send_addr);

  // Memory model: 64 words, one-cycle read latency, host write port for the bench.
  logic [31:0] mem_arr [64];
  logic        hw_en = 1'b0;
  logic [5:0]  hw_a = 6'd0;
  logic [31:0] hw_d = 32'h0;
  int n_info = 0;
  int n_ptr = 0;
  int t_last = 0;
  int t_prev = 0;
  logic [31:0] last_info_addr = 32'h0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (hw_en) mem_arr[hw_a] <= hw_d;
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        mem_arr[mem_addr[7:2]] <= mem_wdata;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_arr[mem_addr[7:2]];
        if (mem_addr[2] == 1'b0) begin
          n_info <= n_info + 1;
          t_prev <= t_last;
          t_last <= cyc;
          last_info_addr <= mem_addr;
        end else begin
          n_ptr <= n_ptr + 1;
        end
      end
    end
  end

  // Frame sender model: answers two cycles after the request, logs the frame.
  int rsp_dly = 0;
  int fr_n = 0;
  logic [31:0] fr_addr [32];
  logic [10:0] fr_len  [32];
  logic        fr_first[32];
  logic        fr_last [32];
  int n_done = 0;
  int n_chain = 0;

  always @(posedge clk) begin
    send_done <= 1'b0;
    if (ev_tx_done)   n_done  <= n_done + 1;
    if (ev_chain_err) n_chain <= n_chain + 1;
    if (send_valid && !send_done) begin
      if (rsp_dly == 2) begin
        send_done <= 1'b1;
        rsp_dly   <= 0;
        fr_addr[fr_n[4:0]]  <= send_addr;
        fr_len[fr_n[4:0]]   <= send_len;
        fr_first[fr_n[4:0]] <= send_first;
        fr_last[fr_n[4:0]]  <= send_last;
        fr_n <= fr_n + 1;
      end else begin
        rsp_dly <= rsp_dly + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mem_put(input int w, input logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1;
    hw_a  = 6'(w);
    hw_d  = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic pulse_force();
    @(negedge clk);
    force_poll = 1'b1;
    @(negedge clk);
    force_poll = 1'b0;
  endtask

  localparam int BASE_W = 16;

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int snap;
    int fcyc;
    for (int i = 0; i < 64; i++) mem_put(i, 32'h0);
    repeat (3) @(negedge clk);
    // Reset state
    chk("R9 reset mem_req", {31'b0, mem_req}, 32'h0);
    chk("R5 reset send_valid", {31'b0, send_valid}, 32'h0);
    chk("R7 reset events", {30'b0, ev_tx_done, ev_chain_err}, 32'h0);
    rst_n = 1'b1;

    // R2: software-owned ring, periodic checks N+3 apart on slot 0
    @(negedge clk);
    cfg_poll_rate = 16'd5;
    cfg_ctrl = (32'd4 << 16) | 32'h9;
    repeat (60) @(negedge clk);
    chk("R2 poll spacing", 32'(t_last - t_prev), 32'd8);
    chk("R2 stays on slot 0", last_info_addr, 32'h40);
    chk("R2 no pointer fetch", 32'(n_ptr), 32'd0);

    // R4: disabled engine ignores timer and force-poll
    cfg_ctrl = (32'd4 << 16) | 32'h1;
    repeat (6) @(negedge clk);
    snap = n_info;
    pulse_force();
    repeat (30) @(negedge clk);
    chk("R4 txen off no check", 32'(n_info - snap), 32'd0);
    cfg_ctrl = (32'd4 << 16) | 32'h8;
    pulse_force();
    repeat (30) @(negedge clk);
    chk("R4 global off no check", 32'(n_info - snap), 32'd0);

    // R3: force-poll from idle, then a second strobe on the acceptance cycle
    cfg_poll_rate = 16'd1000;
    @(negedge clk);
    cfg_ctrl = (32'd4 << 16) | 32'h9;
    repeat (20) @(negedge clk);
    snap = n_info;
    force_poll = 1'b1;
    fcyc = cyc;
    @(negedge clk);
    chk("R3 read issued next cycle", {31'b0, mem_req}, 32'h1);
    @(negedge clk);
    force_poll = 1'b0;
    repeat (40) @(negedge clk);
    chk("R3 force read cycle", 32'(t_prev), 32'(fcyc + 1));
    chk("R3 coincident force rechecks", 32'(t_last), 32'(fcyc + 4));
    chk("R3 exactly two checks", 32'(n_info - snap), 32'd2);

    // R1 R5 R6 R7 R8 R9: sweep over ring lengths
    for (int L = 1; L <= 5; L++) begin
      int fr0;
      int d0;
      int c0;
      int exp_chain;
      cfg_ctrl = 32'h0;
      ack_slow = (L == 3) || (L == 5);
      exp_chain = 0;
      for (int k = 0; k < L; k++) begin
        logic [31:0] inf;
        logic [31:0] ptr;
        ptr = 32'h2000 + 32'((k * 5 + L) * 256);
        inf = 32'h8000_0000 | 32'h0220_0000 | 32'(11'(60 + 97 * k + 13 * L));
        if (k == 1 && L >= 3) begin
          inf = inf | 32'h0001_0000;
          exp_chain++;
        end else begin
          inf = inf | 32'h0003_0000;
        end
        mem_put(BASE_W + 2 * k, inf);
        mem_put(BASE_W + 2 * k + 1, ptr);
      end
      fr0 = fr_n;
      d0 = n_done;
      c0 = n_chain;
      @(negedge clk);
      cfg_ctrl = (32'(L) << 16) | 32'h9;
      pulse_force();
      for (int w = 0; w < 800 && fr_n < fr0 + L; w++) @(negedge clk);
      repeat (40) @(negedge clk);
      chk("R8 frames in ring", 32'(fr_n - fr0), 32'(L));
      for (int k = 0; k < L; k++) begin
        logic [31:0] inf;
        logic [31:0] ptr;
        ptr = 32'h2000 + 32'((k * 5 + L) * 256);
        inf = 32'h8000_0000 | 32'h0220_0000 | 32'(11'(60 + 97 * k + 13 * L));
        inf = inf | ((k == 1 && L >= 3) ? 32'h0001_0000 : 32'h0003_0000);
        chk("R1 pointer used", fr_addr[(fr0 + k) % 32], ptr);
        chk("R5 length", 32'(fr_len[(fr0 + k) % 32]), 32'(inf[10:0]));
        chk("R5 first/last", {30'b0, fr_first[(fr0 + k) % 32], fr_last[(fr0 + k) % 32]},
            {30'b0, inf[16], inf[17]});
        chk("R6 write-back word", mem_arr[BASE_W + 2 * k], wb_exp(inf, stat_of(ptr)));
      end
      chk("R7 done events", 32'(n_done - d0), 32'(L));
      chk("R7 chain events", 32'(n_chain - c0), 32'(exp_chain));
      chk("R8 wrapped to slot 0", last_info_addr, 32'h40);
    end
    ack_slow = 1'b0;

    // R2: engine waits on a software-owned slot even if a later one is ready
    snap = fr_n;
    mem_put(BASE_W + 4, 32'h8003_0040);
    pulse_force();
    repeat (30) @(negedge clk);
    chk("R2 no send past owned slot", 32'(fr_n - snap), 32'd0);
    chk("R2 index held", last_info_addr, 32'h40);
    mem_put(BASE_W, 32'h8003_0050);
    pulse_force();
    repeat (40) @(negedge clk);
    chk("R1 slot 0 sent after handover", 32'(fr_n - snap), 32'd1);
    chk("R1 slot 0 pointer", fr_addr[snap % 32], 32'h2000 + 32'(5 * 256));
    chk("R8 moved to slot 1 and waits", last_info_addr, 32'h48);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule